// File: doc/BRIEF.md
# Debug Trigger Chain Combiner

This block turns the raw match results of ten hardware debug triggers into final firing decisions for a processor pipeline. Each cycle it receives one hit bit and one timing bit per trigger. The comparators that produce those bits sit outside the block. It combines them with a per-trigger enable mask and per-pair chain controls. It then reports which triggers fire, whether a trap is wanted on the current instruction or on the next one, and a single overall hit flag.

The triggers form five fixed pairs: two fetch triggers, two store triggers, two load triggers, one fetch with one store, and one fetch with one load. When a pair is chained, its two members act as one condition. Both must hit, and both must ask for the same trap timing. Chaining the store/store pair is not allowed, so a chain request on that pair is dropped.

The enable mask and the chain bits live in two small configuration registers. Software loads them through a one-write-per-cycle valid/select/data port. All results are registered, so each output reflects the inputs of the cycle before.

Top module: `dbg_trig_combiner`

## Requirements
- R1: A synchronous reset clears the enable mask, the chain bits and every output to zero. Hits that arrive after reset, with no configuration written, fire nothing.
- R2: With `cfg_we` high, `cfg_sel`=0 loads `cfg_wdata[9:0]` into the enable mask and `cfg_sel`=1 loads `cfg_wdata[4:0]` into the chain bits. The new value first applies to hits presented in the cycle after the write.
- R3: Trigger k drives bit k of `fire`. An enabled, unchained trigger that hits in cycle t shows its `fire` bit in cycle t+1.
- R4: A disabled trigger never fires. It also does not count as the hitting partner of a chained pair.
- R5: Pair i is made of triggers 2i and 2i+1 and is governed by chain bit i. When a pair is chained, both triggers fire together only when both are enabled and both hit. Otherwise neither fires.
- R6: In a chained pair whose two timing bits differ, neither trigger fires, even when both hit.
- R7: Chain bit 1 (pair 1, triggers 2 and 3, the store/store pair) is ignored. Those two triggers always behave as unchained.
- R8: A timing bit of 0 means trap on the current instruction and 1 means trap on the next one. `trap_now` is the OR of the fired triggers whose timing was 0, and `trap_next` is the OR of the fired triggers whose timing was 1.
- R9: `any_hit` is the OR of all fired triggers, covering the fetch-side ones (0, 1, 6, 8) and the memory-side ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write valid |
| cfg_sel | input | 1 | Register select: 0 = enable mask, 1 = chain bits |
| cfg_wdata | input | 10 | Configuration write data |
| trig_hit | input | 10 | Raw match result per trigger |
| trig_timing | input | 10 | Per-trigger timing: 0 = current, 1 = next instruction |
| fire | output | 10 | Registered per-trigger fire vector |
| trap_now | output | 1 | A fired trigger asks for a trap on the current instruction |
| trap_next | output | 1 | A fired trigger asks for a trap on the next instruction |
| any_hit | output | 1 | Any trigger fired |

## Verification
The assertions check on every cycle that:
- a disabled trigger stays silent;
- a chained pair fires neither member when only one is live or when the two timing bits differ;
- the store/store pair follows its own hits whatever its chain bit says;
- the trap flags and `any_hit` agree with the fired set.

Only the bench scenarios can show the rest. These cover the exact cycle in which a configuration write takes effect, the decoding of the select line, and the state left by reset. They also include the full fire vector over long random mixes of hits, timings, enables and chain settings, checked against an independent model.

// File: rtl/dbg_trig_combiner.sv
module dbg_trig_combiner #(
  parameter int NPAIR        = 5,
  parameter int NOCHAIN_PAIR = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [2*NPAIR-1:0] cfg_wdata,
  input  logic [2*NPAIR-1:0] trig_hit,
  input  logic [2*NPAIR-1:0] trig_timing,
  output logic [2*NPAIR-1:0] fire,
  output logic              trap_now,
  output logic              trap_next,
  output logic              any_hit
);
  localparam int NTRIG = 2 * NPAIR;

  logic [NTRIG-1:0] en_q, live, fire_d, fire_q;
  logic [NPAIR-1:0] chain_q;
  logic             now_q, next_q, hit_q;

  assign live = trig_hit & en_q;

  for (genvar i = 0; i < NPAIR; i++) begin : g_pair
    logic a, b, same;
    assign a    = live[2*i];
    assign b    = live[2*i+1];
    assign same = trig_timing[2*i] == trig_timing[2*i+1];

    if (i == NOCHAIN_PAIR) begin : g_free
      assign fire_d[2*i+1:2*i] = {b, a};

      AST_NOCHAIN_INDEP: assert property (@(posedge clk) disable iff (rst)
        fire_q[2*i+1:2*i] == $past(live[2*i+1:2*i])); // R7
    end else begin : g_chain
      assign fire_d[2*i+1:2*i] = chain_q[i] ? {2{a & b & same}} : {b, a};

      AST_CHAIN_BOTH: assert property (@(posedge clk) disable iff (rst)
        ($past(chain_q[i]) && !($past(live[2*i]) && $past(live[2*i+1])))
        |-> fire_q[2*i+1:2*i] == 2'b00); // R5
      AST_CHAIN_TIMING: assert property (@(posedge clk) disable iff (rst)
        ($past(chain_q[i]) && ($past(trig_timing[2*i]) != $past(trig_timing[2*i+1])))
        |-> fire_q[2*i+1:2*i] == 2'b00); // R6
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      chain_q <= '0;
      fire_q  <= '0;
      now_q   <= 1'b0;
      next_q  <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      if (cfg_we) begin
        if (cfg_sel) chain_q <= cfg_wdata[NPAIR-1:0];
        else         en_q    <= cfg_wdata;
      end
      fire_q <= fire_d;
      now_q  <= |(fire_d & ~trig_timing);
      next_q <= |(fire_d & trig_timing);
      hit_q  <= |fire_d;
    end
  end

  assign fire      = fire_q;
  assign trap_now  = now_q;
  assign trap_next = next_q;
  assign any_hit   = hit_q;

  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (rst)
    (fire_q & ~$past(en_q)) == '0); // R4
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    (fire_q & ~$past(trig_hit)) == '0); // R3
  AST_TRAP_NOW: assert property (@(posedge clk) disable iff (rst)
    now_q == |(fire_q & ~$past(trig_timing))); // R8
  AST_TRAP_NEXT: assert property (@(posedge clk) disable iff (rst)
    next_q == |(fire_q & $past(trig_timing))); // R8
  AST_HIT_FLAG: assert property (@(posedge clk) disable iff (rst)
    hit_q == (now_q | next_q)); // R9
endmodule

// File: tb/dbg_trig_combiner_test.sv
`timescale 1ns/1ps
module dbg_trig_combiner_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [9:0] cfg_wdata = '0, trig_hit = '0, trig_timing = '0;
  logic [9:0] fire;
  logic       trap_now, trap_next, any_hit;

  int checks = 0, failures = 0;
  logic [9:0] m_en = '0;
  logic [4:0] m_ch = '0;
  logic [9:0] e_fire;
  logic       e_now, e_next, e_hit;
  bit         done = 0;

  always #2.5 clk = ~clk;

  dbg_trig_combiner uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .trig_hit(trig_hit), .trig_timing(trig_timing),
    .fire(fire), .trap_now(trap_now), .trap_next(trap_next), .any_hit(any_hit)
  );

  function automatic logic [9:0] model(logic [9:0] h, logic [9:0] t, logic [9:0] en, logic [4:0] ch);
    logic [9:0] lv = h & en;
    logic [9:0] r = '0;
    for (int i = 0; i < 5; i++) begin
      if (ch[i] && i != 1) begin
        r[2*i]   = lv[2*i] & lv[2*i+1] & (t[2*i] == t[2*i+1]);
        r[2*i+1] = r[2*i];
      end else begin
        r[2*i]   = lv[2*i];
        r[2*i+1] = lv[2*i+1];
      end
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(logic we, logic sel, logic [9:0] wd, logic [9:0] h, logic [9:0] t, string tag);
    @(negedge clk);
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd; trig_hit = h; trig_timing = t;
    e_fire = model(h, t, m_en, m_ch);
    e_now  = |(e_fire & ~t);
    e_next = |(e_fire & t);
    e_hit  = |e_fire;
    if (we) begin
      if (sel) m_ch = wd[4:0];
      else     m_en = wd;
    end
    @(posedge clk); #1;
    chk(tag, fire, e_fire);
    chk("R8 trap_now", trap_now, e_now);
    chk("R8 trap_next", trap_next, e_next);
    chk("R9 any_hit", any_hit, e_hit);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 fire after reset", fire, 10'h000);
    chk("R1 any_hit after reset", any_hit, 1'b0);
    @(negedge clk) rst = 1'b0;

    step(0, 0, 0, 10'h3FF, 10'h000, "R1 hits with cleared enables");
    chk("R1 literal", fire, 10'h000);

    step(1, 0, 10'h3FF, 10'h3FF, 10'h000, "R2 write not yet applied");
    chk("R2 literal old mask", fire, 10'h000);
    step(0, 0, 0, 10'h011, 10'h000, "R2 write applied next cycle");
    chk("R2 literal new mask", fire, 10'h011);

    step(0, 0, 0, 10'h010, 10'h000, "R3 single trigger");
    chk("R3 literal bit4", fire, 10'h010);

    step(0, 0, 0, 10'h201, 10'h200, "R8 both trap classes");
    chk("R8 now", trap_now, 1'b1);
    chk("R8 next", trap_next, 1'b1);

    step(1, 0, 10'h3FE, 0, 0, "R4 mask write");
    step(1, 1, 10'h001, 0, 0, "R2 chain write");
    step(0, 0, 0, 10'h003, 10'h000, "R4 disabled partner");
    chk("R4 literal", fire, 10'h000);
    step(0, 0, 0, 10'h001, 10'h000, "R4 disabled alone");
    chk("R4 literal alone", fire, 10'h000);

    step(1, 0, 10'h3FF, 0, 0, "R2 re-enable");
    step(1, 1, 10'h01F, 0, 0, "R2 chain all");
    step(0, 0, 0, 10'h040, 10'h000, "R5 one of pair");
    chk("R5 literal half", fire, 10'h000);
    step(0, 0, 0, 10'h0C0, 10'h0C0, "R5 both of pair");
    chk("R5 literal both", fire, 10'h0C0);
    chk("R8 literal next only", {trap_now, trap_next}, 2'b01);

    step(0, 0, 0, 10'h300, 10'h100, "R6 timing mismatch");
    chk("R6 literal", fire, 10'h000);
    chk("R9 literal quiet", any_hit, 1'b0);

    step(0, 0, 0, 10'h004, 10'h000, "R7 store pair chain ignored");
    chk("R7 literal", fire, 10'h004);
    chk("R9 literal hit", any_hit, 1'b1);

    for (int n = 0; n < 600; n++) begin
      logic we = ($urandom % 8) == 0;
      step(we, $urandom % 2, 10'($urandom), 10'($urandom | $urandom), 10'($urandom), "R5 R6 random mix");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule